// File: doc/BRIEF.md
# Predicated Subvector Horizontal Reduction Unit

This block walks a vector of VL short subvector groups held in an external register file and, when reduction mode is selected, folds the elements of each group into one scalar. Each group holds 2, 3 or 4 elements. The fold uses one of six integer operations, arranged as a two-level tree, and the scalar for group i goes to destination register base+i. A predicate word enables or disables whole groups: a disabled group skips its write entirely, and no predicate bit ever reaches a single element inside a group.

When reduction mode is off, or the subvector length is 1, the unit copies elements one by one. The predicate is still applied per group. A start pulse launches a run and a one-cycle done pulse closes it. The unit takes one group (or one element) per cycle. It reads through a four-lane combinational read port and writes through a single write port.

Top module: `subred_unit`

## Requirements
- R1: With `red_mode`=1 and `sub_len`!=0, group i (i < VL) takes the `sub_len`+1 elements at source addresses `src_base`+i*(`sub_len`+1)+k and, if enabled, writes their fold to `dst_base`+i.
- R2: With `red_mode`=0 or `sub_len`=0, element e (e < VL*(`sub_len`+1)) is read from `src_base`+e and written unchanged to `dst_base`+e, enabled by predicate bit e/(`sub_len`+1).
- R3: A group whose bit in `pmask` is 0 produces no write, so its destination register(s) keep their previous value; bit i of `pmask` governs group i.
- R4: `op_sel` codes: 0 wrapping add, 1 AND, 2 OR, 3 XOR, 4 signed minimum, 5 signed maximum; the reserved codes 6 and 7 return the left operand.
- R5: `sub_len` encodes the group size as value+1. A 2-element group folds as op(x,y), a 3-element group as op(op(x,y),z), and a 4-element group as op(op(x,y),op(z,w)).
- R6: A run with VL=0 writes nothing and raises `done` right after the accepting edge. A `vec_len` above MAX_VL (64) is treated as 64.
- R7: A run of T groups or elements holds `busy` for T cycles, issues at most one write per cycle, and raises `done` for exactly one cycle, T edges after the accepting edge.
- R8: `start` is ignored while `busy` is high; the running job's results are unaffected.
- R9: After reset, `busy`, `done` and `wr_en` are 0.
- R10: Read lane k (bits k*DW +: DW of `rd_data`) is the register at `rd_addr`+k. All addresses wrap modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a run; sampled only when idle |
| red_mode | input | 1 | Horizontal reduction enable |
| sub_len | input | 2 | Group size minus one |
| op_sel | input | 3 | Fold operation code |
| vec_len | input | 7 | Number of groups (VL) |
| pmask | input | 64 | Group predicate, bit i for group i |
| src_base | input | 8 | First source register |
| dst_base | input | 8 | First destination register |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_addr | output | 8 | Read port address (lane 0) |
| rd_data | input | 256 | Four consecutive registers from rd_addr |
| wr_en | output | 1 | Write strobe |
| wr_addr | output | 8 | Write address |
| wr_data | output | 64 | Write data |

## Verification
The bench uses the defaults: 64-bit elements, MAX_VL of 64 and 8-bit register addresses. With these values the full predicate word, an element-mode run of 256 elements and a clamped vector length are all in range. An 8-bit address also makes wrap-around of both source and destination windows easy to reach. Random runs mix all eight operation codes, every group size, both modes and sparse or dense predicates. Directed runs cover an empty vector, a full 64-group run, a start pulse issued mid-run, and windows that cross address 255.

// File: rtl/subred_pkg.sv
package subred_pkg;
   localparam logic [2:0] OP_ADD = 3'd0;
   localparam logic [2:0] OP_AND = 3'd1;
   localparam logic [2:0] OP_OR  = 3'd2;
   localparam logic [2:0] OP_XOR = 3'd3;
   localparam logic [2:0] OP_MIN = 3'd4;
   localparam logic [2:0] OP_MAX = 3'd5;
   localparam int LANES = 4;
endpackage

// File: rtl/subred_alu.sv
module subred_alu #(
   parameter int DW = 64
) (
   input  logic [2:0]    op,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output logic [DW-1:0] y
);
   import subred_pkg::*;
   generate
      if (DW < 2) begin : g_bad_dw
         $error("subred_alu: DW must be at least 2");
      end
   endgenerate

   always_comb begin
      case (op)
         OP_ADD:  y = a + b;
         OP_AND:  y = a & b;
         OP_OR:   y = a | b;
         OP_XOR:  y = a ^ b;
         OP_MIN:  y = ($signed(a) < $signed(b)) ? a : b;
         OP_MAX:  y = ($signed(a) < $signed(b)) ? b : a;
         default: y = a;
      endcase
   end
endmodule

// File: rtl/subred_tree.sv
module subred_tree #(
   parameter int DW = 64
) (
   input  logic [subred_pkg::LANES*DW-1:0] lanes,
   input  logic [2:0]                      nsub,
   input  logic [2:0]                      op,
   output logic [DW-1:0]                   res
);
   import subred_pkg::*;
   localparam int PAIRS = LANES / 2;

   generate
      if (LANES != 4) begin : g_bad_lanes
         $error("subred_tree: tree is built for four lanes");
      end
   endgenerate

   logic [DW-1:0] elem [LANES];
   logic [DW-1:0] pair [PAIRS];
   logic [DW-1:0] right_in;
   logic [DW-1:0] top_out;

   // level 1: adjacent element pairs
   for (genvar k = 0; k < LANES; k++) begin : g_unpack
      assign elem[k] = lanes[k*DW +: DW];
   end
   for (genvar j = 0; j < PAIRS; j++) begin : g_lvl1
      subred_alu #(.DW(DW)) i_alu (
         .op(op), .a(elem[2*j]), .b(elem[2*j+1]), .y(pair[j])
      );
   end

   // level 2: a 3-group passes its lone third element straight up
   assign right_in = (nsub == 3'd4) ? pair[1] : elem[2];

   subred_alu #(.DW(DW)) i_alu_top (
      .op(op), .a(pair[0]), .b(right_in), .y(top_out)
   );

   always_comb begin
      case (nsub)
         3'd0, 3'd1: res = elem[0];
         3'd2:       res = pair[0];
         default:    res = top_out;
      endcase
   end
endmodule

// File: rtl/subred_ctrl.sv
module subred_ctrl #(
   parameter int MAX_VL = 64,
   parameter int AW     = 8,
   localparam int VLW   = $clog2(MAX_VL + 1),
   localparam int GW    = (MAX_VL > 1) ? $clog2(MAX_VL) : 1,
   localparam int TW    = $clog2(MAX_VL * subred_pkg::LANES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              red_mode,
   input  logic [1:0]        sub_len,
   input  logic [2:0]        op_sel,
   input  logic [VLW-1:0]    vec_len,
   input  logic [MAX_VL-1:0] pmask,
   input  logic [AW-1:0]     src_base,
   input  logic [AW-1:0]     dst_base,
   output logic              busy,
   output logic              done,
   output logic              red_q,
   output logic [2:0]        nsub_q,
   output logic [2:0]        op_q,
   output logic [AW-1:0]     rp_q,
   output logic [AW-1:0]     wp_q,
   output logic              wr_en
);
   generate
      if (MAX_VL < 1 || AW < 2) begin : g_bad_cfg
         $error("subred_ctrl: MAX_VL >= 1 and AW >= 2 required");
      end
   endgenerate

   logic              busy_q, done_q;
   logic [MAX_VL-1:0] pred_q;
   logic [TW-1:0]     total_q, idx_q;
   logic [GW-1:0]     grp_q;
   logic [2:0]        sub_q;
   logic [VLW-1:0]    vl_eff;
   logic              red_n;
   logic [2:0]        nsub_n;
   logic [TW-1:0]     total_n;
   logic              last;

   always_comb begin
      vl_eff  = (vec_len > VLW'(MAX_VL)) ? VLW'(MAX_VL) : vec_len;
      red_n   = red_mode && (sub_len != 2'd0);
      nsub_n  = {1'b0, sub_len} + 3'd1;
      total_n = red_n ? TW'(vl_eff) : TW'(vl_eff) * TW'(nsub_n);
   end

   assign last = (idx_q == total_q - TW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         red_q   <= 1'b0;
         nsub_q  <= 3'd1;
         op_q    <= 3'd0;
         pred_q  <= '0;
         total_q <= '0;
         idx_q   <= '0;
         grp_q   <= '0;
         sub_q   <= '0;
         rp_q    <= '0;
         wp_q    <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start) begin
               red_q   <= red_n;
               nsub_q  <= nsub_n;
               op_q    <= op_sel;
               pred_q  <= pmask;
               total_q <= total_n;
               idx_q   <= '0;
               grp_q   <= '0;
               sub_q   <= '0;
               rp_q    <= src_base;
               wp_q    <= dst_base;
               if (total_n == '0) done_q <= 1'b1;
               else               busy_q <= 1'b1;
            end
         end else begin
            idx_q <= idx_q + TW'(1);
            wp_q  <= wp_q + AW'(1);
            rp_q  <= rp_q + (red_q ? AW'(nsub_q) : AW'(1));
            if (red_q || sub_q == nsub_q - 3'd1) begin
               grp_q <= grp_q + GW'(1);
               sub_q <= '0;
            end else begin
               sub_q <= sub_q + 3'd1;
            end
            if (last) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign busy  = busy_q;
   assign done  = done_q;
   assign wr_en = busy_q && pred_q[grp_q];

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q && !start |=> !done_q);
   // R7
   end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> done_q);
   // R8
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && start |=> $stable(op_q) && $stable(pred_q) && $stable(red_q));
   // R1
   wp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && $past(busy_q) |-> wp_q == $past(wp_q) + AW'(1));
endmodule

// File: rtl/subred_unit.sv
module subred_unit #(
   parameter int DW     = 64,
   parameter int MAX_VL = 64,
   parameter int AW     = 8,
   localparam int VLW   = $clog2(MAX_VL + 1),
   localparam int RDW   = subred_pkg::LANES * DW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              red_mode,
   input  logic [1:0]        sub_len,
   input  logic [2:0]        op_sel,
   input  logic [VLW-1:0]    vec_len,
   input  logic [MAX_VL-1:0] pmask,
   input  logic [AW-1:0]     src_base,
   input  logic [AW-1:0]     dst_base,
   output logic              busy,
   output logic              done,
   output logic [AW-1:0]     rd_addr,
   input  logic [RDW-1:0]    rd_data,
   output logic              wr_en,
   output logic [AW-1:0]     wr_addr,
   output logic [DW-1:0]     wr_data
);
   logic          red_q;
   logic [2:0]    nsub_q, op_q;
   logic [AW-1:0] rp_q, wp_q;
   logic [DW-1:0] fold;

   subred_ctrl #(.MAX_VL(MAX_VL), .AW(AW)) i_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .red_mode(red_mode),
      .sub_len(sub_len), .op_sel(op_sel), .vec_len(vec_len), .pmask(pmask),
      .src_base(src_base), .dst_base(dst_base), .busy(busy), .done(done),
      .red_q(red_q), .nsub_q(nsub_q), .op_q(op_q), .rp_q(rp_q), .wp_q(wp_q),
      .wr_en(wr_en)
   );

   subred_tree #(.DW(DW)) i_tree (
      .lanes(rd_data), .nsub(nsub_q), .op(op_q), .res(fold)
   );

   assign rd_addr = rp_q;
   assign wr_addr = wp_q;
   assign wr_data = red_q ? fold : rd_data[DW-1:0];

   // R7
   wr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> busy);
endmodule

// File: tb/test_subred_unit.sv
module test_subred_unit;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         red_mode = 1'b0;
   logic [1:0]   sub_len = '0;
   logic [2:0]   op_sel = '0;
   logic [6:0]   vec_len = '0;
   logic [63:0]  pmask = '0;
   logic [7:0]   src_base = '0;
   logic [7:0]   dst_base = '0;
   logic         busy, done, wr_en;
   logic [7:0]   rd_addr, wr_addr;
   logic [255:0] rd_data;
   logic [63:0]  wr_data;

   logic [63:0]  src [256];
   logic [63:0]  dst [256];
   int           wcnt = 0;
   int           errors = 0;
   int           checks = 0;
   int           cycles = 0;

   always #4 clk = ~clk;

   subred_unit i_subred_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .red_mode(red_mode),
      .sub_len(sub_len), .op_sel(op_sel), .vec_len(vec_len), .pmask(pmask),
      .src_base(src_base), .dst_base(dst_base), .busy(busy), .done(done),
      .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data)
   );

   // R10 lane k = register rd_addr+k, wrapping at 256
   assign rd_data = {src[8'(rd_addr + 8'd3)], src[8'(rd_addr + 8'd2)],
                     src[8'(rd_addr + 8'd1)], src[rd_addr]};

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) dst[i] <= {32'hD5D5_0000 + 32'(i), 32'(i) * 32'h9E37_79B9};
      end else if (wr_en) begin
         dst[wr_addr] <= wr_data;
         wcnt <= wcnt + 1;
      end
   end

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      wait (cycles >= 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=run completion", cycles);
      summary();
   end

   task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   function automatic logic [63:0] f_op(input logic [2:0] o, input logic [63:0] a, input logic [63:0] b);
      case (o)
         3'd0: return a + b;
         3'd1: return a & b;
         3'd2: return a | b;
         3'd3: return a ^ b;
         3'd4: return ($signed(a) < $signed(b)) ? a : b;
         3'd5: return ($signed(a) > $signed(b)) ? a : b;
         default: return a;
      endcase
   endfunction

   task automatic run(input bit m, input logic [1:0] sl, input logic [2:0] o, input logic [6:0] v,
                      input logic [63:0] p, input logic [7:0] a, input logic [7:0] t,
                      input bit poke, input string tag);
      logic [63:0] exp [256];
      int n, ve, tot, wexp, w0, cnt, bad, badi;
      bit red;
      n   = int'(sl) + 1;
      red = m && (sl != 2'd0);
      ve  = (v > 7'd64) ? 64 : int'(v);
      tot = red ? ve : ve * n;
      wexp = 0;
      for (int i = 0; i < 256; i++) exp[i] = dst[i];
      for (int i = 0; i < tot; i++) begin
         int g;
         logic [63:0] val;
         logic [7:0] ad;
         g = red ? i : i / n;
         if (red) begin
            logic [63:0] l, r;
            ad = 8'(int'(a) + i * n);
            // R5 tree shape: (x op y) op (z op w) / (x op y) op z
            l = f_op(o, src[ad], src[8'(ad + 8'd1)]);
            if (n == 2) val = l;
            else begin
               r = (n == 4) ? f_op(o, src[8'(ad + 8'd2)], src[8'(ad + 8'd3)]) : src[8'(ad + 8'd2)];
               val = f_op(o, l, r);
            end
         end else begin
            val = src[8'(int'(a) + i)];
         end
         if (p[g]) begin
            exp[8'(int'(t) + i)] = val;
            wexp++;
         end
      end
      w0 = wcnt;
      red_mode = m; sub_len = sl; op_sel = o; vec_len = v; pmask = p;
      src_base = a; dst_base = t; start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      cnt = 0;
      while (!done && cnt < 400) begin
         // R8 try to restart mid-run with a different job
         if (poke && cnt == 1) begin
            start = 1'b1; red_mode = !m; op_sel = o + 3'd1; pmask = ~p; src_base = a + 8'd7;
         end else start = 1'b0;
         @(posedge clk); #1;
         cnt++;
      end
      start = 1'b0;
      chk(cnt == tot, {tag, " R7 done latency"}, 64'(cnt), 64'(tot));
      @(posedge clk); #1;
      chk(!done && !busy, {tag, " R7 done width"}, {62'd0, done, busy}, 64'd0);
      chk(wcnt - w0 == wexp, {tag, " R3 write count"}, 64'(wcnt - w0), 64'(wexp));
      bad = 0; badi = 0;
      for (int i = 0; i < 256; i++) if (dst[i] !== exp[i]) begin
         if (bad == 0) badi = i;
         bad++;
      end
      chk(bad == 0, {tag, " dest contents"}, dst[badi], exp[badi]);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 256; i++) src[i] = {$urandom(), $urandom()};
      src[10] = 64'h8000_0000_0000_0000;
      src[11] = 64'h7FFF_FFFF_FFFF_FFFF;
      src[12] = 64'hFFFF_FFFF_FFFF_FFFF;
      src[13] = 64'h0000_0000_0000_0001;
      repeat (3) @(posedge clk);
      #1;
      // R9
      chk(!busy && !done && !wr_en, "R9 reset outputs", {61'd0, busy, done, wr_en}, 64'd0);
      rst_n = 1'b1;
      @(posedge clk); #1;

      // directed corners
      run(1, 2'd1, 3'd0, 7'd0, 64'hFFFF, 8'd0, 8'd0, 0, "R6 empty");
      run(1, 2'd3, 3'd4, 7'd1, 64'd1, 8'd10, 8'd40, 0, "R4 R5 min4 signed");
      run(1, 2'd3, 3'd5, 7'd1, 64'd1, 8'd10, 8'd41, 0, "R4 R5 max4 signed");
      run(1, 2'd2, 3'd0, 7'd1, 64'd1, 8'd11, 8'd42, 0, "R4 R5 add3 wrap");
      run(1, 2'd3, 3'd0, 7'd64, '1, 8'd3, 8'd100, 0, "R1 full");
      run(1, 2'd3, 3'd3, 7'd100, '1, 8'd0, 8'd0, 0, "R6 clamp");
      run(0, 2'd3, 3'd0, 7'd8, 64'h55, 8'd20, 8'd60, 0, "R2 element svm0");
      run(1, 2'd0, 3'd1, 7'd9, 64'h1A5, 8'd30, 8'd90, 0, "R2 element len1");
      run(1, 2'd1, 3'd2, 7'd6, 64'd0, 8'd0, 8'd0, 0, "R3 all off");
      run(1, 2'd3, 3'd3, 7'd5, 64'h0B, 8'd250, 8'd254, 0, "R10 wrap");
      run(1, 2'd1, 3'd6, 7'd4, 64'hF, 8'd50, 8'd150, 0, "R4 reserved");
      run(1, 2'd2, 3'd2, 7'd10, 64'h3DF, 8'd5, 8'd200, 1, "R8 start busy");
      run(0, 2'd2, 3'd5, 7'd12, 64'hA5A, 8'd70, 8'd10, 1, "R8 start busy elem");

      // constrained random
      for (int k = 0; k < 40; k++) begin
         logic [63:0] pm;
         pm = {$urandom(), $urandom()};
         if (k % 4 == 1) pm = pm & {$urandom(), $urandom()};
         run(1'($urandom() % 4 != 0), 2'($urandom()), 3'($urandom()),
             7'($urandom() % 70), pm, 8'($urandom()), 8'($urandom()),
             ($urandom() % 5 == 0), "R1 R2 R4 R5 random");
      end
      summary();
   end
endmodule